// File: doc/BRIEF.md
# Slow-Domain Register Write Pacer

This block sits on the path from a fast processor bus to a register file that runs on a separate, much slower clock. Some registers in that file need time to settle after a write. For those registers, the slow side must see a fixed number of its own clock edges after a write before the next write or read may reach them. The pacer enforces that spacing in hardware, so software needs no delay loops.

The bus uses a simple valid/ready handshake. An access is taken in any fast cycle in which `req_valid` and `req_ready` are both high. In that same cycle it appears on the downstream strobe `dn_*`. A write to a guarded register flips a request toggle. That toggle crosses into the slow domain through a synchronizer. The slow side then counts `GAP_EDGES` of its clock edges and flips an acknowledge toggle, which crosses back through a second synchronizer. While the two toggles differ, `busy` is high. During that time any access to a guarded register is held by pulling `req_ready` low, and it is taken unchanged once the window ends. Accesses to other addresses pass through at all times. Reads never open a window. `busy` is a plain status output that software can poll through its own status path.

Top module: `slow_reg_write_pacer`

## Requirements
- R1: While `frst_n` is low, `busy` is 0 and `req_ready` is 1, even for a write request to a guarded address.
- R2: The fast cycle after a write to a guarded address is accepted, `busy` is 1. `busy` is never 1 unless such a write is still outstanding.
- R3: While `busy` is 1, a write to a guarded address is held: `req_ready` is 0 and `dn_valid` is 0. The write is accepted unchanged once `busy` returns to 0.
- R4: While `busy` is 1, a read of a guarded address is held in the same way.
- R5: Reads never open a window. After a read is accepted with `busy` at 0, `busy` stays 0. Consecutive reads of guarded addresses with `busy` at 0 are accepted one per fast cycle with no stall.
- R6: An access to an address outside the guarded set is never stalled (`req_ready` is 1), even while `busy` is 1. A write to such an address does not open a window.
- R7: The guarded set is addresses 0x00 (counter), 0x01 (match 0), 0x02 (match 1), 0x03 (load), 0x09 (trim) and 0x0A (data) on a 6-bit address. After a guarded write is accepted, the next guarded access is accepted no sooner than `SYNC_STAGES + GAP_EDGES + 1` slow rising edges later.
- R8: With the slow clock period longer than `SYNC_STAGES + 1` fast periods, `busy` returns to 0 after `SYNC_STAGES + GAP_EDGES + 1` or `SYNC_STAGES + GAP_EDGES + 2` slow rising edges have occurred after the accepting fast edge.
- R9: In every cycle, `dn_valid` equals `req_valid && req_ready`. In an accepting cycle, `dn_write`, `dn_addr` and `dn_wdata` equal the request fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast bus clock |
| frst_n | input | 1 | Active-low reset, fast domain |
| sclk | input | 1 | Slow register clock |
| srst_n | input | 1 | Active-low reset, slow domain |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Access may be taken this cycle |
| dn_valid | output | 1 | Access forwarded to the register file |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | AW | Forwarded address |
| dn_wdata | output | DW | Forwarded write data |
| busy | output | 1 | A guarded write is still completing |

## Verification
The bench tests a guarded write that follows another guarded write with no gap, and a guarded read that follows a guarded write with no gap. A design that tracks only writes would let the read through early, and a design that drops held accesses would never forward them. The bench also sends writes to unguarded addresses while the window is open; a design that stalls every address would stall these, and one that opens a window for any write would show `busy`. Runs of guarded reads check that reads neither stall nor raise `busy`. The window length is counted in slow edges, so a counter that is off by one in either direction, or a missing synchronizer stage, falls outside the allowed range.

// File: rtl/pacer_pkg.sv
`timescale 1ns/100ps
package pacer_pkg;
   typedef enum logic {
      TMR_IDLE  = 1'b0,
      TMR_COUNT = 1'b1
   } tmr_state_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pacer_sync.sv
`timescale 1ns/100ps
module pacer_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 1,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pacer_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pacer_addr_match.sv
`timescale 1ns/100ps
module pacer_addr_match #(
   parameter int unsigned                     AW        = 6,
   parameter int unsigned                     NPROT     = 6,
   parameter logic [NPROT-1:0][AW-1:0]        PROT_ADDR = {6'h0A, 6'h09, 6'h03, 6'h02, 6'h01, 6'h00}
) (
   input  logic [AW-1:0]    addr,
   output logic [NPROT-1:0] hit_vec,
   output logic             hit
);
   if (NPROT < 1) begin : g_bad_nprot
      $error("pacer_addr_match: NPROT must be at least 1");
   end

   for (genvar i = 0; i < NPROT; i++) begin : g_cmp
      assign hit_vec[i] = (addr == PROT_ADDR[i]);
      for (genvar j = i + 1; j < NPROT; j++) begin : g_uniq
         if (PROT_ADDR[i] == PROT_ADDR[j]) begin : g_dup
            $error("pacer_addr_match: guarded addresses must be distinct");
         end
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/pacer_slow_timer.sv
`timescale 1ns/100ps
module pacer_slow_timer
   import pacer_pkg::*;
#(
   parameter int unsigned GAP_EDGES   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic sclk,
   input  logic srst_n,
   input  logic req_tgl,
   output logic ack_tgl
);
   localparam int unsigned CW = cnt_bits(GAP_EDGES);

   if (GAP_EDGES < 1) begin : g_bad_gap
      $error("pacer_slow_timer: GAP_EDGES must be at least 1");
   end

   logic          req_s;
   logic          seen;
   logic [CW-1:0] cnt;
   tmr_state_e    state;

   pacer_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_req_sync (
      .clk   (sclk),
      .rst_n (srst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   always_ff @(posedge sclk or negedge srst_n) begin
      if (!srst_n) begin
         seen    <= 1'b0;
         cnt     <= '0;
         state   <= TMR_IDLE;
         ack_tgl <= 1'b0;
      end else begin
         unique case (state)
            TMR_IDLE: begin
               if (req_s != seen) begin
                  seen  <= req_s;
                  cnt   <= CW'(GAP_EDGES - 1);
                  state <= TMR_COUNT;
               end
            end
            TMR_COUNT: begin
               if (cnt == '0) begin
                  ack_tgl <= ~ack_tgl;
                  state   <= TMR_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= TMR_IDLE;
         endcase
      end
   end

   // R7
   no_overlap_chk: assert property (@(posedge sclk) disable iff (!srst_n)
      (state == TMR_COUNT) |-> (req_s == seen));

   // R8
   ack_after_count_chk: assert property (@(posedge sclk) disable iff (!srst_n)
      (ack_tgl != $past(ack_tgl)) |-> ($past(state) == TMR_COUNT));
endmodule

// File: rtl/slow_reg_write_pacer.sv
`timescale 1ns/100ps
module slow_reg_write_pacer #(
   parameter int unsigned              AW          = 6,
   parameter int unsigned              DW          = 16,
   parameter int unsigned              NPROT       = 6,
   parameter logic [NPROT-1:0][AW-1:0] PROT_ADDR   = {6'h0A, 6'h09, 6'h03, 6'h02, 6'h01, 6'h00},
   parameter int unsigned              GAP_EDGES   = 3,
   parameter int unsigned              SYNC_STAGES = 2
) (
   input  logic          fclk,
   input  logic          frst_n,
   input  logic          sclk,
   input  logic          srst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          dn_valid,
   output logic          dn_write,
   output logic [AW-1:0] dn_addr,
   output logic [DW-1:0] dn_wdata,
   output logic          busy
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("slow_reg_write_pacer: AW and DW must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("slow_reg_write_pacer: SYNC_STAGES must be at least 2");
   end

   logic [NPROT-1:0] hit_vec;
   logic             prot_hit;
   logic             wr_tgl;
   logic             ack_tgl_s;
   logic             ack_tgl_f;
   logic             guarded_wr;

   pacer_addr_match #(.AW(AW), .NPROT(NPROT), .PROT_ADDR(PROT_ADDR)) u_match (
      .addr    (req_addr),
      .hit_vec (hit_vec),
      .hit     (prot_hit)
   );

   pacer_slow_timer #(.GAP_EDGES(GAP_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .sclk    (sclk),
      .srst_n  (srst_n),
      .req_tgl (wr_tgl),
      .ack_tgl (ack_tgl_s)
   );

   pacer_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (fclk),
      .rst_n (frst_n),
      .d     (ack_tgl_s),
      .q     (ack_tgl_f)
   );

   assign busy       = wr_tgl ^ ack_tgl_f;
   assign req_ready  = !(busy && prot_hit);
   assign dn_valid   = req_valid && req_ready;
   assign dn_write   = req_write;
   assign dn_addr    = req_addr;
   assign dn_wdata   = req_wdata;
   assign guarded_wr = dn_valid && req_write && prot_hit;

   always_ff @(posedge fclk or negedge frst_n) begin
      if (!frst_n) wr_tgl <= 1'b0;
      else if (guarded_wr) wr_tgl <= ~wr_tgl;
   end

   // R2
   busy_rise_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      guarded_wr |=> busy);

   // R7
   gap_hold_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      guarded_wr |=> !(dn_valid && prot_hit));

   // R6
   open_path_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      (req_valid && !prot_hit) |-> req_ready);

   // R5
   read_no_window_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      (dn_valid && !req_write && !busy) |=> !busy);

   // R3
   held_no_fwd_chk: assert property (@(posedge fclk) disable iff (!frst_n)
      (busy && prot_hit && $past(busy)) |-> !dn_valid);
endmodule

// File: tb/tb_slow_reg_write_pacer.sv
`timescale 1ns/100ps
module tb_slow_reg_write_pacer;
   localparam int AW   = 6;
   localparam int DW   = 16;
   localparam int GAP  = 3;
   localparam int SYNC = 2;
   localparam int LOW  = GAP + SYNC + 1;
   localparam int HIGH = LOW + 1;
   localparam logic [AW-1:0] PA [6] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h09, 6'h0A};

   logic          fclk = 1'b0;
   logic          sclk = 1'b0;
   logic          frst_n = 1'b0;
   logic          srst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, dn_valid, dn_write, busy;
   logic [AW-1:0] dn_addr;
   logic [DW-1:0] dn_wdata;

   int  vectors = 0;
   int  miscompares = 0;
   int  scnt = 0;
   int  last_pw_s = 0;
   bit  pw_pending = 1'b0;
   bit  had_pw = 1'b0;
   bit  prev_busy = 1'b0;

   slow_reg_write_pacer #(.AW(AW), .DW(DW), .GAP_EDGES(GAP), .SYNC_STAGES(SYNC)) dut (
      .fclk(fclk), .frst_n(frst_n), .sclk(sclk), .srst_n(srst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
      .dn_wdata(dn_wdata), .busy(busy)
   );

   always #2 fclk = ~fclk;
   initial begin
      #0.5;
      forever #15 sclk = ~sclk;
   end
   always @(posedge sclk) scnt <= scnt + 1;

   function automatic bit is_prot(input logic [AW-1:0] a);
      for (int i = 0; i < 6; i++) if (a == PA[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #600000;
      chk(1'b0, "R8 watchdog expired", 0, 1);
      finish_run();
   end

   // busy window monitor (R2, R8)
   initial begin
      forever begin
         @(negedge fclk);
         if (frst_n) begin
            if (busy && !pw_pending) chk(1'b0, "R2 busy with no write outstanding", 1, 0);
            if (pw_pending) begin
               int el;
               el = scnt - last_pw_s;
               if (!busy && prev_busy) begin
                  chk(el >= LOW && el <= HIGH, "R8 window length in slow edges", el, LOW);
                  pw_pending = 1'b0;
               end else if (!busy) begin
                  chk(1'b0, "R2 busy did not rise", 0, 1);
                  pw_pending = 1'b0;
               end else if (el > HIGH) begin
                  chk(1'b0, "R8 busy overdue", el, HIGH);
                  pw_pending = 1'b0;
               end
            end
            prev_busy = busy;
         end
      end
   end

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int stalls);
      bit p;
      int el;
      p = is_prot(a);
      @(negedge fclk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      #1;
      stalls = 0;
      forever begin
         if (p) chk(req_ready == !pw_pending, wr ? "R3 guarded write ready" : "R4 guarded read ready",
                    int'(req_ready), int'(!pw_pending));
         else   chk(req_ready, "R6 open address stalled", int'(req_ready), 1);
         if (req_ready) break;
         chk(!dn_valid, "R3 held access forwarded", int'(dn_valid), 0);
         stalls++;
         if (stalls > 400) begin
            chk(1'b0, "R8 stall never ends", stalls, 400);
            break;
         end
         @(negedge fclk);
         #1;
      end
      chk(dn_valid && dn_write == wr && dn_addr == a && dn_wdata == d,
          "R9 forwarded access", int'({dn_valid, dn_write, dn_addr}), int'({1'b1, wr, a}));
      @(posedge fclk);
      if (p && had_pw) begin
         el = scnt - last_pw_s;
         chk(el >= LOW, "R7 guarded spacing in slow edges", el, LOW);
      end
      if (p && wr) begin
         last_pw_s  = scnt;
         pw_pending = 1'b1;
         had_pw     = 1'b1;
      end
      #1;
      if (p && wr) chk(busy, "R2 busy after guarded write", int'(busy), 1);
      else if (!pw_pending) chk(!busy, wr ? "R6 open write opened window" : "R5 read opened window",
                                int'(busy), 0);
   endtask

   task automatic idle(input int n);
      @(negedge fclk);
      req_valid = 1'b0;
      repeat (n) @(negedge fclk);
   endtask

   task automatic wait_idle();
      idle(1);
      while (pw_pending) @(negedge fclk);
      repeat (2) @(negedge fclk);
   endtask

   initial begin
      int st;
      void'($urandom(32'h1d5e));
      repeat (3) @(negedge fclk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = PA[0];
      #1;
      chk(!busy, "R1 busy in reset", int'(busy), 0);
      chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
      @(negedge fclk);
      req_valid = 1'b0;
      repeat (2) @(negedge fclk);
      frst_n = 1'b1; srst_n = 1'b1;
      repeat (4) @(negedge fclk);

      // R3: guarded write straight after guarded write
      access(1'b1, PA[0], 16'h1234, st);
      access(1'b1, PA[1], 16'hBEEF, st);
      chk(st > 0, "R3 second write not held", st, 1);
      wait_idle();

      // R4: guarded read straight after guarded write
      access(1'b1, PA[3], 16'h00AA, st);
      access(1'b0, PA[3], 16'h0000, st);
      chk(st > 0, "R4 read after write not held", st, 1);
      wait_idle();

      // R6: open addresses while the window is open
      access(1'b1, PA[4], 16'h5A5A, st);
      access(1'b1, 6'h20, 16'h7777, st);
      chk(st == 0, "R6 open write stalled", st, 0);
      access(1'b0, 6'h21, 16'h0000, st);
      chk(st == 0, "R6 open read stalled", st, 0);
      wait_idle();

      // R5: back-to-back guarded reads
      for (int i = 0; i < 8; i++) begin
         access(1'b0, PA[i % 6], 16'h0000, st);
         chk(st == 0, "R5 back-to-back read stalled", st, 0);
      end
      idle(2);
      access(1'b1, 6'h30, 16'h4321, st);
      chk(!busy, "R6 open write busy", int'(busy), 0);
      wait_idle();

      // mixed random traffic
      for (int n = 0; n < 300; n++) begin
         logic [AW-1:0] a;
         bit            w;
         w = 1'($urandom);
         if ($urandom % 2) a = PA[$urandom % 6];
         else              a = AW'($urandom);
         access(w, a, DW'($urandom), st);
         if ($urandom % 3 == 0) idle($urandom % 3);
      end
      wait_idle();
      finish_run();
   end
endmodule